// File: doc/BRIEF.md
# Level-Interrupt EOI Handler with Storm Throttle

This block sits beside an interrupt redirection table and reacts to end-of-interrupt broadcasts. Each broadcast carries a vector, a trigger-mode flag and a directed-EOI flag. The block walks the table one pin per clock in ascending order. For every pin whose programmed vector equals the broadcast vector, it emits an acknowledge pulse. For a level-mode broadcast without directed EOI, it also emits a pulse that clears that pin's in-service (remote-IRR) bit. If that pin is unmasked and its input request is still asserted, the block asks the delivery datapath to send the interrupt again.

Each pin has a counter of back-to-back re-deliveries. When a pin's count reaches the storm limit, the counter returns to zero. No immediate re-delivery is requested. Instead a single shared deferral timer is started. When the timer expires, every level-mode pin that is still requesting and has its in-service bit clear gets a delivery request. The timer's length is a cycle count parameter. Starting the timer while it already runs does nothing. The delivery datapath, the table storage and the in-service bits themselves live outside the block.

Top module: `eoi_storm_throttle`

## Requirements
- R1: A broadcast is accepted on a clock edge where `eoi_valid_i` is high and `busy_o` is low. The broadcast vector is compared with pin k's vector at bits [8k+7:8k] of `ent_vector_i`, sampled on the (k+1)-th edge after acceptance. On a match, `ack_o[k]` is high for exactly the one cycle following that edge. At most one `ack_o` bit is high at a time.
- R2: If `eoi_level_i` is 0 (edge mode) or `directed_eoi_i` is 1, a matching pin gets only its acknowledge. There is no clear pulse and no delivery request, and the pin's counter is unchanged.
- R3: If `eoi_level_i` is 1 and `directed_eoi_i` is 0, a matching pin also gets `rirr_clr_o[k]` in the same cycle as its acknowledge.
- R4: In the R3 case, if `ent_mask_i[k]` is 0 (unmasked) and `pin_pending_i[k]` is 1, the pin's counter increments. When the new count is below `STORM_LIMIT`, `deliver_o[k]` rises in the same cycle as the acknowledge.
- R5: In the R3 case, if the pin is masked or not pending, its counter is cleared to 0 and no delivery is requested for it.
- R6: When an increment would make the count equal `STORM_LIMIT`, the counter returns to 0. No immediate delivery is requested, and the deferral timer starts.
- R7: `DEFER_CYCLES` cycles after the timer starts, `deliver_o` is raised for one cycle on every pin with `ent_level_i`=1, `pin_pending_i`=1 and `pin_rirr_i`=0.
- R8: A start request while the timer runs and has not yet reached its final cycle is ignored. The expiry keeps its original time.
- R9: `busy_o` stays high for exactly `NUM_PINS` cycles after acceptance. A broadcast offered while busy is ignored.
- R10: Reset clears all outputs and all counters, and it cancels a running deferral timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoi_valid_i | input | 1 | Broadcast offered this cycle |
| eoi_vector_i | input | 8 | Broadcast vector |
| eoi_level_i | input | 1 | 1 = level-mode broadcast, 0 = edge |
| directed_eoi_i | input | 1 | 1 = directed EOI enabled, suppress clear and re-delivery |
| ent_vector_i | input | 8*NUM_PINS | Per-pin programmed vectors, pin k at [8k+7:8k] |
| ent_level_i | input | NUM_PINS | Per-pin trigger mode, 1 = level |
| ent_mask_i | input | NUM_PINS | Per-pin mask, 1 = masked |
| pin_pending_i | input | NUM_PINS | Per-pin input request still asserted |
| pin_rirr_i | input | NUM_PINS | Per-pin in-service bit |
| busy_o | output | 1 | Scan in progress |
| ack_o | output | NUM_PINS | Acknowledge pulse per pin |
| rirr_clr_o | output | NUM_PINS | Clear-in-service pulse per pin |
| deliver_o | output | NUM_PINS | Delivery request per pin |

## Verification
The bench builds the block with four pins, a storm limit of 3 and a deferral of 20 cycles. With a limit of 3, a storm is reached after only three back-to-back level broadcasts. With a 20-cycle deferral, both the expiry-driven rescan and a second storm arriving while the timer still runs happen many times within a short run. Four pins keep every scan short, so broadcasts offered while busy, and matches on the first and last pin, occur often under random stimulus.

// File: rtl/eoi_pkg.sv
package eoi_pkg;
    localparam int VEC_W = 8;
    typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/eoi_vec_match.sv
module eoi_vec_match
    import eoi_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  vec_t                      key_i,
    input  logic [NUM_PINS*VEC_W-1:0] table_i,
    output logic [NUM_PINS-1:0]       hit_o
);
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_cmp
        assign hit_o[g] = (table_i[g*VEC_W +: VEC_W] == key_i);
    end
endmodule

// File: rtl/eoi_defer_timer.sv
module eoi_defer_timer #(
    parameter int DEFER_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    output logic expire_o
);
    localparam int TW = (DEFER_CYCLES < 2) ? 1 : $clog2(DEFER_CYCLES);

    typedef struct packed {
        logic          run;
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    assign expire_o = q.run && (q.cnt == '0);

    always_comb begin
        d = q;
        if (arm_i && (!q.run || expire_o)) begin
            d.run = 1'b1;
            d.cnt = TW'(DEFER_CYCLES - 1);
        end else if (expire_o) begin
            d.run = 1'b0;
        end else if (q.run) begin
            d.cnt = q.cnt - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // a running timer keeps counting down whatever arm_i does
    p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && !expire_o) |=> (q.run && q.cnt == $past(q.cnt) - TW'(1)));

    p_expire_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !arm_i) |=> !q.run);
endmodule

// File: rtl/eoi_storm_throttle.sv
module eoi_storm_throttle
    import eoi_pkg::*;
#(
    parameter int NUM_PINS     = 24,
    parameter int STORM_LIMIT  = 10000,
    parameter int DEFER_CYCLES = 1000000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      eoi_valid_i,
    input  logic [VEC_W-1:0]          eoi_vector_i,
    input  logic                      eoi_level_i,
    input  logic                      directed_eoi_i,
    input  logic [NUM_PINS*VEC_W-1:0] ent_vector_i,
    input  logic [NUM_PINS-1:0]       ent_level_i,
    input  logic [NUM_PINS-1:0]       ent_mask_i,
    input  logic [NUM_PINS-1:0]       pin_pending_i,
    input  logic [NUM_PINS-1:0]       pin_rirr_i,
    output logic                      busy_o,
    output logic [NUM_PINS-1:0]       ack_o,
    output logic [NUM_PINS-1:0]       rirr_clr_o,
    output logic [NUM_PINS-1:0]       deliver_o
);
    localparam int IW = (NUM_PINS < 2) ? 1 : $clog2(NUM_PINS);
    localparam int CW = $clog2(STORM_LIMIT + 1);

    typedef struct packed {
        logic                         busy;
        logic [IW-1:0]                idx;
        vec_t                         vec;
        logic                         lvl;
        logic                         dir;
        logic [NUM_PINS-1:0][CW-1:0]  cnt;
        logic [NUM_PINS-1:0]          ack;
        logic [NUM_PINS-1:0]          clr;
        logic [NUM_PINS-1:0]          dlv;
    } st_t;

    st_t q, d;
    logic [NUM_PINS-1:0] hit;
    logic                arm, expire;

    eoi_vec_match #(.NUM_PINS(NUM_PINS)) i_match (
        .key_i   (q.vec),
        .table_i (ent_vector_i),
        .hit_o   (hit)
    );

    eoi_defer_timer #(.DEFER_CYCLES(DEFER_CYCLES)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm),
        .expire_o (expire)
    );

    always_comb begin
        d     = q;
        d.ack = '0;
        d.clr = '0;
        d.dlv = '0;
        arm   = 1'b0;
        if (q.busy) begin
            if (hit[q.idx]) begin
                d.ack[q.idx] = 1'b1;
                if (q.lvl && !q.dir) begin
                    d.clr[q.idx] = 1'b1;
                    if (!ent_mask_i[q.idx] && pin_pending_i[q.idx]) begin
                        if (q.cnt[q.idx] == CW'(STORM_LIMIT - 1)) begin
                            d.cnt[q.idx] = '0;
                            arm          = 1'b1;
                        end else begin
                            d.cnt[q.idx] = q.cnt[q.idx] + CW'(1);
                            d.dlv[q.idx] = 1'b1;
                        end
                    end else begin
                        d.cnt[q.idx] = '0;
                    end
                end
            end
            if (q.idx == IW'(NUM_PINS - 1)) d.busy = 1'b0;
            else                            d.idx  = q.idx + IW'(1);
        end else if (eoi_valid_i) begin
            d.busy = 1'b1;
            d.idx  = '0;
            d.vec  = eoi_vector_i;
            d.lvl  = eoi_level_i;
            d.dir  = directed_eoi_i;
        end
        if (expire) d.dlv = d.dlv | (ent_level_i & pin_pending_i & ~pin_rirr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o     = q.busy;
    assign ack_o      = q.ack;
    assign rirr_clr_o = q.clr;
    assign deliver_o  = q.dlv;

    p_ack_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.ack));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |=> (q.ack == '0 && q.clr == '0));

    p_directed_no_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.dir) |=> (q.clr == '0));

    p_scan_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.idx == IW'(NUM_PINS - 1)) |=> !q.busy);

    p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.idx != IW'(NUM_PINS - 1)) |=>
            (q.busy && q.idx == $past(q.idx) + IW'(1) && $stable(q.vec)));

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_cnt_chk
        p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
            q.cnt[g] < CW'(STORM_LIMIT));
    end
endmodule

// File: tb/test_eoi_storm_throttle.sv
module test_eoi_storm_throttle;
    localparam int N   = 4;
    localparam int LIM = 3;
    localparam int DLY = 20;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           eoi_valid = 1'b0;
    logic [7:0]     eoi_vector = '0;
    logic           eoi_level = 1'b0;
    logic           directed = 1'b0;
    logic [N*8-1:0] ent_vector = '0;
    logic [N-1:0]   ent_level = '0, ent_mask = '0, pin_pending = '0, pin_rirr = '0;
    logic           busy;
    logic [N-1:0]   ack, rirr_clr, deliver;

    eoi_storm_throttle #(.NUM_PINS(N), .STORM_LIMIT(LIM), .DEFER_CYCLES(DLY)) i_eoi_storm_throttle (
        .clk(clk), .rst_n(rst_n), .eoi_valid_i(eoi_valid), .eoi_vector_i(eoi_vector),
        .eoi_level_i(eoi_level), .directed_eoi_i(directed), .ent_vector_i(ent_vector),
        .ent_level_i(ent_level), .ent_mask_i(ent_mask), .pin_pending_i(pin_pending),
        .pin_rirr_i(pin_rirr), .busy_o(busy), .ack_o(ack), .rirr_clr_o(rirr_clr),
        .deliver_o(deliver)
    );

    int    checks = 0, fails = 0;
    string tag = "R10";
    bit    done = 1'b0;

    // reference state built from the requirements
    bit           m_busy, m_lvl, m_dir, m_trun;
    int           m_idx, m_tcnt;
    logic [7:0]   m_vec;
    int           m_cnt[N];
    logic [N-1:0] e_ack = '0, e_clr = '0, e_dlv = '0;

    task automatic model_step();
        logic [N-1:0] na = '0, nc = '0, nd = '0;
        bit arm = 1'b0, ex;
        if (!rst_n) begin
            m_busy = 0; m_idx = 0; m_trun = 0; m_tcnt = 0;
            for (int k = 0; k < N; k++) m_cnt[k] = 0;
            e_ack = '0; e_clr = '0; e_dlv = '0;
            return;
        end
        if (m_busy) begin
            int i = m_idx;
            if (ent_vector[i*8 +: 8] == m_vec) begin
                na[i] = 1'b1;
                if (m_lvl && !m_dir) begin
                    nc[i] = 1'b1;
                    if (!ent_mask[i] && pin_pending[i]) begin
                        if (m_cnt[i] + 1 == LIM) begin m_cnt[i] = 0; arm = 1'b1; end
                        else begin m_cnt[i]++; nd[i] = 1'b1; end
                    end else m_cnt[i] = 0;
                end
            end
            if (m_idx == N - 1) m_busy = 0; else m_idx++;
        end else if (eoi_valid) begin
            m_busy = 1; m_idx = 0; m_vec = eoi_vector; m_lvl = eoi_level; m_dir = directed;
        end
        ex = m_trun && m_tcnt == 0;
        if (ex) nd = nd | (ent_level & pin_pending & ~pin_rirr);
        if (arm && (!m_trun || ex)) begin m_trun = 1; m_tcnt = DLY - 1; end
        else if (ex) m_trun = 0;
        else if (m_trun) m_tcnt--;
        e_ack = na; e_clr = nc; e_dlv = nd;
    endtask

    task automatic check(string what, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL [%s] %s act=%b exp=%b", tag, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("ack (R1)", ack, e_ack);
        check("rirr_clr (R3)", rirr_clr, e_clr);
        check("deliver (R4/R7)", deliver, e_dlv);
        check("busy (R9)", N'(busy), N'(m_busy));
    endtask

    task automatic eoi(logic [7:0] v, bit lvl, bit dir);
        eoi_valid = 1'b1; eoi_vector = v; eoi_level = lvl; directed = dir;
        cyc();
        eoi_valid = 1'b0;
        repeat (N) cyc();
    endtask

    initial begin
        void'($urandom(32'd2024));
        tag = "R10";
        repeat (2) cyc();
        rst_n = 1'b1;
        cyc();

        tag = "R1";
        ent_vector = {8'h41, 8'h22, 8'h41, 8'h41};
        eoi(8'h41, 0, 0);
        eoi(8'h22, 0, 0);

        tag = "R2";
        ent_level = '1; pin_pending = '1;
        eoi(8'h41, 1, 1);
        eoi(8'h41, 0, 0);

        tag = "R4";
        eoi(8'h41, 1, 0);

        tag = "R5";
        ent_mask = 4'b0010; pin_pending = 4'b0111;
        eoi(8'h41, 1, 0);

        tag = "R6";
        ent_mask = '0; pin_pending = '1;
        eoi(8'h41, 1, 0);

        tag = "R8";
        eoi(8'h41, 1, 0);
        eoi(8'h41, 1, 0);

        tag = "R7";
        pin_rirr = 4'b0100;
        repeat (DLY + 4) cyc();
        pin_rirr = '0;

        tag = "R9";
        eoi_valid = 1'b1; eoi_vector = 8'h41; eoi_level = 1'b0; directed = 1'b0;
        cyc();
        eoi_vector = 8'h22;
        repeat (N) cyc();
        eoi_valid = 1'b0;
        repeat (N + 1) cyc();

        tag = "R10";
        repeat (3) eoi(8'h41, 1, 0);
        repeat (3) cyc();
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1;
        repeat (DLY + 4) cyc();

        tag = "random";
        for (int k = 0; k < N; k++) ent_vector[k*8 +: 8] = 8'h40 + 8'($urandom_range(0, 2));
        ent_level = N'($urandom);
        for (int t = 0; t < 3000; t++) begin
            pin_pending = N'($urandom);
            pin_rirr    = N'($urandom) & N'($urandom);
            ent_mask    = N'($urandom) & N'($urandom) & N'($urandom);
            eoi_valid   = ($urandom_range(0, 3) == 0);
            eoi_vector  = 8'h40 + 8'($urandom_range(0, 2));
            eoi_level   = ($urandom_range(0, 3) != 0);
            directed    = ($urandom_range(0, 7) == 0);
            if (t % 500 == 499) ent_level = N'($urandom);
            cyc();
        end
        eoi_valid = 1'b0;
        repeat (N + 2) cyc();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL [watchdog] run (R9) act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule